// File: doc/BRIEF.md
# Trap Request Arbiter

This block sits between the units that can raise a trap (alignment checking, instruction decode, control-register access checking and external interrupt lines) and the CPU control logic. Each category has its own request line and a cause word. While it is idle, the arbiter picks one enabled request and registers it. It then presents the request to the control logic as a single valid flag with its cause word.

The chosen request is held unchanged until the control logic acknowledges it. The acknowledge is routed back only to the source that won, and that source then withdraws its request. Other sources that are still asserting are not lost: they take part in arbitration again in the cycle after the acknowledge.

The control logic drives an enable per category, which may change every cycle. This lets it keep some categories out of arbitration during particular pipeline stages.

Top module: `trap_req_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `irq_valid` is low and every bit of `src_ack` is low.
- R2: When `irq_valid` is low and at least one source has both its request and its enable high at a rising edge, `irq_valid` is high after that edge. `irq_cause` then equals the winning source's cause word as sampled at that edge. Source i's cause occupies bits [i*CAUSE_W +: CAUSE_W] of `src_cause`.
- R3: Among eligible sources the lowest index wins. Index 0 is alignment faults, 1 is decode faults, 2 is register-access faults and 3 is external interrupts.
- R4: A source whose enable is low at the arbitration edge is not chosen. When no source is both requesting and enabled, `irq_valid` stays low.
- R5: While `irq_valid` is high and `ctl_ack` is low, `irq_valid` stays high and `irq_cause` does not change. This holds even if requests, enables or cause words change, including the arrival of a higher-priority request.
- R6: While `irq_valid` is high, `src_ack` carries `ctl_ack` to the bit of the held source only, in the same cycle. It is zero on every other bit.
- R7: A rising edge with `irq_valid` and `ctl_ack` both high clears `irq_valid` for at least one cycle. Requests still pending then compete in that next cycle and can be granted at its closing edge.
- R8: `ctl_ack` while `irq_valid` is low has no effect: `src_ack` stays zero and `irq_valid` stays low.
- R9: At most one bit of `src_ack` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronous to clk |
| src_req | input | NUM_SRC | Request line per category |
| src_en | input | NUM_SRC | Arbitration enable per category |
| src_cause | input | NUM_SRC*CAUSE_W | Cause word per category, source i at [i*CAUSE_W +: CAUSE_W] |
| src_ack | output | NUM_SRC | Acknowledge returned to the held source |
| ctl_ack | input | 1 | Acknowledge from control logic for the presented request |
| irq_valid | output | 1 | A request is being presented |
| irq_cause | output | CAUSE_W | Cause word of the presented request |

## Verification
The bench builds the arbiter with its defaults: four categories and 32-bit cause words. Four categories make every priority pairing reachable, along with masking of a winner, an all-masked cycle and a lower source waiting behind a higher one. The full cause width lets the bench give each source a distinct word, so a wrong selection or a cause changing during a hold shows up on `irq_cause`.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;

  // Category slots, lowest index wins arbitration.
  typedef enum int unsigned {
    CAT_ALIGN  = 0,
    CAT_DECODE = 1,
    CAT_CSRACC = 2,
    CAT_EXTIRQ = 3
  } trap_cat_e;

  localparam int unsigned TRAP_NUM_CAT = 4;

endpackage

// File: rtl/trap_prio_pick.sv
module trap_prio_pick #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic [NUM_SRC-1:0] eligible,
  output logic [NUM_SRC-1:0] win_oh,
  output logic               win_any
);

  // taken[i] is set when some index below i is eligible.
  logic [NUM_SRC:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign win_oh[i]    = eligible[i] & ~taken[i];
    assign taken[i + 1] = taken[i] | eligible[i];
  end

  assign win_any = taken[NUM_SRC];

endmodule

// File: rtl/trap_cause_sel.sv
module trap_cause_sel #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned CAUSE_W = 32
) (
  input  logic [NUM_SRC-1:0]         sel_oh,
  input  logic [NUM_SRC*CAUSE_W-1:0] cause_bus,
  output logic [CAUSE_W-1:0]         cause_out
);

  // AND-OR reduction over a one-hot select.
  always_comb begin
    cause_out = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      cause_out = cause_out | (cause_bus[i*CAUSE_W +: CAUSE_W] & {CAUSE_W{sel_oh[i]}});
    end
  end

endmodule

// File: rtl/trap_req_arbiter.sv
module trap_req_arbiter #(
  parameter int unsigned NUM_SRC = trap_arb_pkg::TRAP_NUM_CAT,
  parameter int unsigned CAUSE_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         src_req,
  input  logic [NUM_SRC-1:0]         src_en,
  input  logic [NUM_SRC*CAUSE_W-1:0] src_cause,
  output logic [NUM_SRC-1:0]         src_ack,
  input  logic                       ctl_ack,
  output logic                       irq_valid,
  output logic [CAUSE_W-1:0]         irq_cause
);

  logic               hold_q, hold_d;
  logic [NUM_SRC-1:0] owner_q, owner_d;
  logic [CAUSE_W-1:0] cause_q;
  logic               cause_ld;

  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] win_oh;
  logic               win_any;
  logic [CAUSE_W-1:0] win_cause;

  assign eligible = src_req & src_en;

  trap_prio_pick #(
    .NUM_SRC (NUM_SRC)
  ) u_pick (
    .eligible (eligible),
    .win_oh   (win_oh),
    .win_any  (win_any)
  );

  trap_cause_sel #(
    .NUM_SRC (NUM_SRC),
    .CAUSE_W (CAUSE_W)
  ) u_csel (
    .sel_oh    (win_oh),
    .cause_bus (src_cause),
    .cause_out (win_cause)
  );

  // Next-state: arbitrate only while idle, release only on acknowledge.
  always_comb begin
    hold_d   = hold_q;
    owner_d  = owner_q;
    cause_ld = 1'b0;
    if (!hold_q) begin
      if (win_any) begin
        hold_d   = 1'b1;
        owner_d  = win_oh;
        cause_ld = 1'b1;
      end
    end else if (ctl_ack) begin
      hold_d  = 1'b0;
      owner_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      owner_q <= '0;
    end else begin
      hold_q  <= hold_d;
      owner_q <= owner_d;
    end
  end

  // Cause word is data only: loaded under enable, no reset needed.
  always_ff @(posedge clk) begin
    if (cause_ld) begin
      cause_q <= win_cause;
    end
  end

  // Route the control acknowledge back to the held source.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
    assign src_ack[i] = hold_q & ctl_ack & owner_q[i];
  end

  assign irq_valid = hold_q;
  assign irq_cause = cause_q;

endmodule

// File: rtl/trap_req_arbiter_chk.sv
module trap_req_arbiter_chk #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned CAUSE_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_SRC-1:0]         src_req,
  input logic [NUM_SRC-1:0]         src_en,
  input logic [NUM_SRC*CAUSE_W-1:0] src_cause,
  input logic [NUM_SRC-1:0]         src_ack,
  input logic                       ctl_ack,
  input logic                       irq_valid,
  input logic [CAUSE_W-1:0]         irq_cause
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!irq_valid && (src_ack == '0));
    end
  end

  a_r2_grant_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && |(src_req & src_en)) |=> irq_valid);

  // R3: slot 0 always wins when eligible, and its cause is the one latched.
  a_r3_top_slot_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && src_req[0] && src_en[0]) |=> (irq_cause == $past(src_cause[CAUSE_W-1:0])));

  a_r4_nothing_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && !(|(src_req & src_en))) |=> !irq_valid);

  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ctl_ack) |=> (irq_valid && $stable(irq_cause)));

  a_r6_single_ack_routed: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ctl_ack) |-> ($countones(src_ack) == 1));

  a_r7_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ctl_ack) |=> !irq_valid);

  a_r8_no_ack_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (src_ack == '0));

  a_r9_ack_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack));

endmodule

bind trap_req_arbiter trap_req_arbiter_chk #(
  .NUM_SRC (NUM_SRC),
  .CAUSE_W (CAUSE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_req   (src_req),
  .src_en    (src_en),
  .src_cause (src_cause),
  .src_ack   (src_ack),
  .ctl_ack   (ctl_ack),
  .irq_valid (irq_valid),
  .irq_cause (irq_cause)
);

// File: tb/trap_req_arbiter_test.sv
`timescale 1ns/1ps
module trap_req_arbiter_test;
  import trap_arb_pkg::*;

  localparam int unsigned N = 4;
  localparam int unsigned W = 32;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   src_req;
  logic [N-1:0]   src_en;
  logic [N*W-1:0] src_cause;
  logic [N-1:0]   src_ack;
  logic           ctl_ack;
  logic           irq_valid;
  logic [W-1:0]   irq_cause;

  int n_checks = 0;
  int n_fails  = 0;

  trap_req_arbiter #(.NUM_SRC(N), .CAUSE_W(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .src_en    (src_en),
    .src_cause (src_cause),
    .src_ack   (src_ack),
    .ctl_ack   (ctl_ack),
    .irq_valid (irq_valid),
    .irq_cause (irq_cause)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] cause_of(int i);
    return 32'hCA00_0000 | 32'(i << 8) | 32'(i + 1);
  endfunction

  task automatic load_causes();
    for (int i = 0; i < N; i++) src_cause[i*W +: W] = cause_of(i);
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One table row: inputs for a cycle, ack expected in that cycle,
  // and the presented state expected after its closing edge.
  typedef struct packed {
    logic [3:0] req;
    logic [3:0] en;
    logic       ack;
    logic [3:0] exp_ack;
    logic       exp_valid;
    logic [1:0] exp_src;
  } vec_t;

  localparam vec_t VEC [0:21] = '{
    '{4'b0000, 4'b1111, 1'b0, 4'b0000, 1'b0, 2'd0}, // R4 idle, none
    '{4'b1000, 4'b1111, 1'b0, 4'b0000, 1'b1, 2'd3}, // R2 external
    '{4'b1001, 4'b1111, 1'b0, 4'b0000, 1'b1, 2'd3}, // R5 higher arrives, held
    '{4'b1001, 4'b1111, 1'b1, 4'b1000, 1'b0, 2'd0}, // R6 R7 ack to 3
    '{4'b0001, 4'b1111, 1'b0, 4'b0000, 1'b1, 2'd0}, // R7 pending 0 granted
    '{4'b0001, 4'b1111, 1'b1, 4'b0001, 1'b0, 2'd0}, // R6
    '{4'b0110, 4'b1111, 1'b0, 4'b0000, 1'b1, 2'd1}, // R3 decode over csr
    '{4'b0110, 4'b1111, 1'b1, 4'b0010, 1'b0, 2'd0}, // R6
    '{4'b0100, 4'b1111, 1'b0, 4'b0000, 1'b1, 2'd2}, // R7 csr reconsidered
    '{4'b0100, 4'b1111, 1'b1, 4'b0100, 1'b0, 2'd0}, // R6
    '{4'b1111, 4'b1110, 1'b0, 4'b0000, 1'b1, 2'd1}, // R4 slot 0 masked
    '{4'b1111, 4'b0000, 1'b1, 4'b0010, 1'b0, 2'd0}, // R6 enables irrelevant
    '{4'b1101, 4'b0000, 1'b0, 4'b0000, 1'b0, 2'd0}, // R4 all masked
    '{4'b1101, 4'b0000, 1'b1, 4'b0000, 1'b0, 2'd0}, // R8 idle ack
    '{4'b1101, 4'b1000, 1'b0, 4'b0000, 1'b1, 2'd3}, // R4 only ext enabled
    '{4'b1101, 4'b0000, 1'b0, 4'b0000, 1'b1, 2'd3}, // R5 enable drop no revoke
    '{4'b1101, 4'b1111, 1'b1, 4'b1000, 1'b0, 2'd0}, // R6
    '{4'b0101, 4'b1111, 1'b0, 4'b0000, 1'b1, 2'd0}, // R3 align over csr
    '{4'b0101, 4'b1111, 1'b1, 4'b0001, 1'b0, 2'd0}, // R6
    '{4'b0100, 4'b1111, 1'b0, 4'b0000, 1'b1, 2'd2}, // R2
    '{4'b0100, 4'b1111, 1'b1, 4'b0100, 1'b0, 2'd0}, // R9 single ack
    '{4'b0000, 4'b1111, 1'b0, 4'b0000, 1'b0, 2'd0}  // R4
  };

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    src_req = '0;
    src_en  = '0;
    ctl_ack = 1'b0;
    load_causes();

    // R1: reset state, with activity on the inputs.
    repeat (2) @(negedge clk);
    src_req = 4'b1111; src_en = 4'b1111; ctl_ack = 1'b1;
    @(negedge clk);
    chk("R1 valid in reset", 64'(irq_valid), 64'd0);
    chk("R1 ack in reset", 64'(src_ack), 64'd0);
    src_req = '0; ctl_ack = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 valid after release", 64'(irq_valid), 64'd0);
    chk("R1 ack after release", 64'(src_ack), 64'd0);

    // Table walk
    for (int k = 0; k < 22; k++) begin
      @(negedge clk);
      src_req = VEC[k].req;
      src_en  = VEC[k].en;
      ctl_ack = VEC[k].ack;
      #1;
      chk($sformatf("R6 ack row %0d", k), 64'(src_ack), 64'(VEC[k].exp_ack));
      @(posedge clk); #1;
      chk($sformatf("R2 valid row %0d", k), 64'(irq_valid), 64'(VEC[k].exp_valid));
      if (VEC[k].exp_valid) begin
        chk($sformatf("R3 cause row %0d", k), 64'(irq_cause), 64'(cause_of(int'(VEC[k].exp_src))));
      end
    end

    // R2 R5: cause captured at grant edge, later changes ignored.
    @(negedge clk);
    ctl_ack = 1'b0;
    src_en  = 4'b1111;
    src_req = 4'b0100;
    src_cause[CAT_CSRACC*W +: W] = 32'h1234_5678;
    @(posedge clk); #1;
    chk("R2 captured cause", 64'(irq_cause), 64'h1234_5678);
    @(negedge clk);
    src_cause[CAT_CSRACC*W +: W] = 32'hDEAD_0000;
    src_req = 4'b0101;
    src_cause[CAT_ALIGN*W +: W] = 32'h0BAD_0001;
    @(posedge clk); #1;
    chk("R5 cause stable in hold", 64'(irq_cause), 64'h1234_5678);
    chk("R5 valid in hold", 64'(irq_valid), 64'd1);
    @(negedge clk);
    ctl_ack = 1'b1;
    #1;
    chk("R6 ack to csr slot", 64'(src_ack), 64'b0100);
    @(posedge clk); #1;
    chk("R7 gap after ack", 64'(irq_valid), 64'd0);
    @(negedge clk);
    ctl_ack = 1'b0;
    src_req = 4'b0001;
    @(posedge clk); #1;
    chk("R7 waiting slot granted", 64'(irq_valid), 64'd1);
    chk("R3 waiting slot cause", 64'(irq_cause), 64'h0BAD_0001);

    // R1: reset in the middle of a hold clears everything.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset drops valid", 64'(irq_valid), 64'd0);
    ctl_ack = 1'b1;
    #1;
    chk("R1 no ack in reset", 64'(src_ack), 64'd0);
    @(negedge clk);
    ctl_ack = 1'b0;
    src_req = '0;
    rst_n = 1'b1;
    load_causes();
    @(posedge clk); #1;
    chk("R1 idle after second reset", 64'(irq_valid), 64'd0);

    // R8: acknowledge pulses while idle leave the block idle.
    @(negedge clk);
    ctl_ack = 1'b1;
    #1;
    chk("R8 no ack idle", 64'(src_ack), 64'd0);
    @(posedge clk); #1;
    chk("R8 still idle", 64'(irq_valid), 64'd0);
    @(negedge clk);
    ctl_ack = 1'b0;
    src_req = 4'b1000;
    @(posedge clk); #1;
    chk("R2 grant after idle ack", 64'(irq_valid), 64'd1);
    chk("R2 ext cause", 64'(irq_cause), 64'(cause_of(CAT_EXTIRQ)));

    @(negedge clk);
    finish_run();
  end

endmodule